// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets each of a configurable number of processor cores interrupt any core in the group, itself included, and hand it a 16-bit payload together with the identity of the sender. Every core owns an eight-byte window on a simple 32-bit register bus. The first word of the window is a command word. The core writes it to issue requests. The second word is a read-only status word. It reports whether that core has an interrupt waiting, which core raised it, and the payload that came with it.

A sender writes its own command word with the generate bit set and the target core's index in the destination field. The controller then latches a pending flag, the sender's index and the payload in the target's slot, and drives that target's interrupt line high. The target clears its interrupt by writing its own command word with the acknowledge bit set. Registers are 32-bit words. Software places them on the bus in big-endian byte order, so the byte at the lowest address holds bits 31:24. Only whole-word accesses are decoded, and address bits 1:0 are not looked at.

Top module: `ipi_ctrl`

## Requirements
- R1: After synchronous reset every interrupt output is low, every status word reads zero, and the read data output is zero.
- R2: Core c's command word sits at byte address 8c and its status word at 8c+4. Address bits 1:0 are ignored.
- R3: When a write to core s's command word has bit 30 (generate) set and bits 29:16 (destination) hold a value d below the core count, the slot of core d latches pending, source s and payload bits 15:0. Output irq_out[d] is high from the clock edge that takes the write.
- R4: A read strobe loads bus_rdata at that clock edge, and bus_rdata holds its value until the next read. A status read returns bit 31 as 0, bit 30 as the pending flag, bits 29:16 as the source index and bits 15:0 as the payload.
- R5: A write to core s's command word with bit 31 (acknowledge) set clears core s's pending flag and its interrupt output. Other cores are not affected.
- R6: A generate aimed at a core that is already pending keeps it pending and replaces the stored source and payload.
- R7: A single write that sets both acknowledge and generate, with the writer's own index as destination, leaves the writer pending with the new source and payload.
- R8: A generate whose destination is at or above the core count raises no interrupt and changes no stored state.
- R9: Writes at addresses at or above 8 × core count change nothing. Reads there, and reads of any command word, return zero.
- R10: A command-word write with bits 31 and 30 both clear changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data, valid after the edge that takes the strobe |
| irq_out | output | NCORES | Interrupt line for each core, high while that core is pending |

## Verification
A flipped or stuck pending flag shows up on irq_out at the clock edge after the write that should have set or cleared it. A wrong stored source or payload stays hidden until someone reads the status word, and then appears in bus_rdata one edge after the read strobe. For that reason the bench reads every target's status after each generate and compares the interrupt vector on every cycle. Writes that should be ignored (an out-of-range destination, an address past the window, a word with no command bits) are each followed at once by an interrupt compare and a status readback.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 14;
  localparam int PAYLOAD_W = 16;

  // command word layout (bit 31 down to bit 0)
  typedef struct packed {
    logic                 ack;      // bit 31
    logic                 gen;      // bit 30
    logic [FIELD_W-1:0]   dst;      // bits 29:16
    logic [PAYLOAD_W-1:0] payload;  // bits 15:0
  } cmd_word_t;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic                 pend,
    input logic [FIELD_W-1:0]   src,
    input logic [PAYLOAD_W-1:0] data
  );
    return {1'b0, pend, src, data};
  endfunction

endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8,
  parameter int IDXW   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_stat,
  output logic [IDXW-1:0]   idx
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic              unused_lo;

  assign slot      = addr[ADDR_W-1:3];
  assign hit       = (int'(slot) < NCORES);
  assign is_stat   = addr[2];
  assign idx       = slot[IDXW-1:0];
  assign unused_lo = ^addr[1:0];

endmodule

// File: rtl/ipi_cmd.sv
module ipi_cmd
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int IDXW   = 2
) (
  input  logic                 wr,
  input  logic                 hit,
  input  logic                 is_stat,
  input  logic [IDXW-1:0]      idx,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NCORES-1:0]    gen_vec,
  output logic [NCORES-1:0]    ack_vec,
  output logic [IDXW-1:0]      src,
  output logic [PAYLOAD_W-1:0] payload
);
  cmd_word_t cw;
  logic      cmd_wr;

  assign cw      = cmd_word_t'(wdata);
  assign cmd_wr  = wr && hit && !is_stat;
  assign src     = idx;
  assign payload = cw.payload;

  for (genvar c = 0; c < NCORES; c++) begin : g_sel
    assign gen_vec[c] = cmd_wr && cw.gen && (cw.dst == FIELD_W'(c));
    assign ack_vec[c] = cmd_wr && cw.ack && (idx == IDXW'(c));
  end

endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
#(
  parameter int IDXW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gen_i,
  input  logic                 ack_i,
  input  logic [IDXW-1:0]      src_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 pend_o,
  output logic [IDXW-1:0]      src_o,
  output logic [PAYLOAD_W-1:0] data_o
);
  logic                 pend_q;
  logic [IDXW-1:0]      src_q;
  logic [PAYLOAD_W-1:0] data_q;

  // generate takes priority over acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      src_q  <= '0;
      data_q <= '0;
    end else if (gen_i) begin
      pend_q <= 1'b1;
      src_q  <= src_i;
      data_q <= payload_i;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign src_o  = src_q;
  assign data_o = data_q;

  AST_GEN_LATCH: assert property (@(posedge clk) disable iff (rst)
    gen_i |=> (pend_q && src_q == $past(src_i) && data_q == $past(payload_i))); // R3
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !gen_i) |=> !pend_q); // R5
  AST_RISE_NEEDS_GEN: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(gen_i)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!gen_i && !ack_i) |=> (pend_q == $past(pend_q) && data_q == $past(data_q))); // R10

endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int IDXW   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd,
  input  logic                           hit,
  input  logic                           is_stat,
  input  logic [IDXW-1:0]                idx,
  input  logic [NCORES-1:0][WORD_W-1:0]  stat_words,
  output logic [WORD_W-1:0]              rdata
);
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      if (hit && is_stat) rdata_q <= stat_words[idx];
      else                rdata_q <= '0;
    end
  end

  assign rdata = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q)); // R4
  AST_RSV_BIT: assert property (@(posedge clk) disable iff (rst)
    rd |=> !rdata_q[31]); // R4

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  output logic [NCORES-1:0]   irq_out
);
  localparam int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1;

  logic                          hit, is_stat;
  logic [IDXW-1:0]               idx;
  logic [NCORES-1:0]             gen_vec, ack_vec, pend;
  logic [IDXW-1:0]               cmd_src;
  logic [PAYLOAD_W-1:0]          cmd_payload;
  logic [NCORES-1:0][WORD_W-1:0] stat_words;

  ipi_addr_dec #(.NCORES(NCORES), .ADDR_W(ADDR_W), .IDXW(IDXW)) u_dec (
    .addr(bus_addr), .hit(hit), .is_stat(is_stat), .idx(idx)
  );

  ipi_cmd #(.NCORES(NCORES), .IDXW(IDXW)) u_cmd (
    .wr(bus_wr), .hit(hit), .is_stat(is_stat), .idx(idx), .wdata(bus_wdata),
    .gen_vec(gen_vec), .ack_vec(ack_vec), .src(cmd_src), .payload(cmd_payload)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_slot
    logic [IDXW-1:0]      s_src;
    logic [PAYLOAD_W-1:0] s_data;

    ipi_slot #(.IDXW(IDXW)) u_slot (
      .clk(clk), .rst(rst), .gen_i(gen_vec[c]), .ack_i(ack_vec[c]),
      .src_i(cmd_src), .payload_i(cmd_payload),
      .pend_o(pend[c]), .src_o(s_src), .data_o(s_data)
    );

    assign stat_words[c] = pack_status(pend[c], FIELD_W'(s_src), s_data);
  end

  ipi_rd_mux #(.NCORES(NCORES), .IDXW(IDXW)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .hit(hit), .is_stat(is_stat),
    .idx(idx), .stat_words(stat_words), .rdata(bus_rdata)
  );

  assign irq_out = pend;

  AST_BAD_DST_NOP: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && !is_stat && bus_wdata[30] && !bus_wdata[31] &&
     int'(bus_wdata[29:16]) >= NCORES) |=> (irq_out == $past(irq_out))); // R8
  AST_OUTSIDE_NOP: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> (irq_out == $past(irq_out))); // R9

endmodule

// File: tb/sim_ipi_ctrl.sv
module sim_ipi_ctrl;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference state
  int          m_pend[N];
  int          m_src[N];
  int          m_dat[N];
  logic [31:0] m_rd = '0;

  always #2.5 clk = ~clk;

  ipi_ctrl #(.NCORES(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_pend[i] = 0; m_src[i] = 0; m_dat[i] = 0;
      end
      m_rd = '0;
    end else begin
      int a;
      a = int'(bus_addr);
      if (bus_rd) begin
        if (a < N*8 && bus_addr[2])
          m_rd = {1'b0, m_pend[a/8] != 0, 14'(m_src[a/8]), 16'(m_dat[a/8])};
        else
          m_rd = '0;
      end
      if (bus_wr && a < N*8 && !bus_addr[2]) begin
        if (bus_wdata[31]) m_pend[a/8] = 0;
        if (bus_wdata[30] && int'(bus_wdata[29:16]) < N) begin
          m_pend[bus_wdata[29:16]] = 1;
          m_src[bus_wdata[29:16]]  = a/8;
          m_dat[bus_wdata[29:16]]  = int'(bus_wdata[15:0]);
        end
      end
    end
  end

  function automatic logic [N-1:0] model_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (m_pend[i] != 0);
    return v;
  endfunction

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (irq_out !== model_irq()) begin
        n_fail++;
        $display("FAIL R3/R5 irq_out per-cycle: actual %b expected %b", irq_out, model_irq());
      end
      n_chk++;
      if (bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R4 bus_rdata per-cycle: actual %h expected %h", bus_rdata, m_rd);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", 32'(irq_out), 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(12); check("R1 status after reset", bus_rdata, 32'h0);

    // R3 core 0 raises core 2
    wr(0, 32'h4002BEEF); check("R3 irq to core 2", 32'(irq_out), 32'h4);
    rd(8'h14); check("R4 status core 2", bus_rdata, 32'h4000BEEF);
    repeat (3) @(negedge clk);
    check("R4 rdata held", bus_rdata, 32'h4000BEEF);

    // R6 core 1 overwrites core 2
    wr(8, 32'h40021234); check("R6 still pending", 32'(irq_out), 32'h4);
    rd(8'h14); check("R6 new src and payload", bus_rdata, 32'h40011234);

    // R2 low address bits ignored: core 1 at 0x0B raises core 3
    wr(8'h0B, 32'h40030055); check("R2 irq core 3", 32'(irq_out), 32'hC);
    rd(8'h1F); check("R2 status core 3", bus_rdata, 32'h40010055);

    // R5 core 2 acknowledges
    wr(8'h10, 32'h80000000); check("R5 ack core 2", 32'(irq_out), 32'h8);

    // R7 core 3 ack and self generate in one write
    wr(8'h18, 32'hC003ABCD); check("R7 gen wins", 32'(irq_out), 32'h8);
    rd(8'h1C); check("R7 status core 3", bus_rdata, 32'h4003ABCD);

    // R8 destination out of range
    wr(0, 32'h40040001); check("R8 irq unchanged", 32'(irq_out), 32'h8);
    rd(4); check("R8 status core 0 untouched", bus_rdata, 32'h0);
    wr(0, 32'h7FFF0001); check("R8 max dst irq unchanged", 32'(irq_out), 32'h8);

    // R9 outside window and command reads
    wr(8'h20, 32'h40000001); check("R9 write outside", 32'(irq_out), 32'h8);
    rd(4); check("R9 status core 0 untouched", bus_rdata, 32'h0);
    rd(8'h1C); check("R9 prep read", bus_rdata, 32'h4003ABCD);
    rd(8'h24); check("R9 read outside", bus_rdata, 32'h0);
    rd(8'h18); check("R9 command word reads zero", bus_rdata, 32'h0);

    // R10 no command bits
    wr(8'h18, 32'h00000077); check("R10 irq unchanged", 32'(irq_out), 32'h8);
    rd(8'h1C); check("R10 status core 3 unchanged", bus_rdata, 32'h4003ABCD);

    // R5 ack does not touch others
    wr(0, 32'h40000009); check("R3 self raise core 0", 32'(irq_out), 32'h9);
    wr(8'h18, 32'h80000000); check("R5 ack core 3 only", 32'(irq_out), 32'h1);
    wr(0, 32'h80000000); check("R5 ack core 0", 32'(irq_out), 32'h0);

    // every source to every destination, model compared each cycle
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        wr(s*8, {2'b01, 14'(d), 16'(s*256 + d*17 + 3)});
        rd(d*8 + 4);
        check("R4 sweep status", bus_rdata, {2'b01, 14'(s), 16'(s*256 + d*17 + 3)});
      end
    end
    for (int c = 0; c < N; c++) wr(c*8, 32'h80000000);
    check("R5 all acked", 32'(irq_out), 32'h0);

    // R1 reset mid-run
    wr(8, 32'h40010042); rd(8'h0C);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 irq cleared by reset", 32'(irq_out), 32'h0);
    check("R1 rdata cleared by reset", bus_rdata, 32'h0);
    rst = 1'b0;
    rd(8'h0C); check("R1 status cleared by reset", bus_rdata, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule